// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block is the exception-sequencing stage of a small pipelined soft processor. Each cycle it looks at the instruction in the execute stage, the hardware request lines and the current status word. From these it decides whether to leave the flow alone, take a non-maskable debug request, take a software trap, take a maskable interrupt, or execute a trap-return. When it takes an exception it writes the status word into a shadow copy and clears the interrupt enable bit. It then issues a one-cycle redirect carrying the handler address and the return address that the pipeline writes back.

The handler address for maskable interrupts and traps comes from a 64-entry table of flops. The pipeline loads the table through a simple write port. The non-maskable request goes to a fixed address set by a parameter. A trap-return redirects to a register operand supplied by decode and restores the status word from its shadow copy. A build parameter removes all hardware-interrupt logic and keeps only traps, returns and status writes.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the status word is 8'h3F (enable clear, priority 63, spare bit clear), the shadow copy is 0, and redir_o and ret_we_o are low.
- R2: The status word has the enable bit at bit 7, a spare bit at bit 6 and the priority field at bits 5:0. A valid instruction with st_we_i loads st_wdata_i at the next edge, unless that cycle also takes an exception or a trap-return.
- R3: A maskable request on irq_i[n] (n from 1 to 63) is taken only when the enable bit is 1, n is below the priority field, valid_i is high, in_dslot_i is low and redir_o is low. When several are pending, the lowest n wins.
- R4: Taking any exception copies the old status word into the shadow copy, clears the enable bit, keeps bit 6, and sets the priority field to the taken number (0 for the non-maskable request).
- R5: The redirect target for a maskable interrupt or trap of number n is table entry n, written through vec_we_i/vec_idx_i/vec_data_i. For an interrupt, ret_addr_o is pc_i of the interrupted instruction, and ret_we_o pulses together with redir_o.
- R6: A trap (is_trap_i, number trap_num_i) is taken whatever the enable bit and priority field hold, with return address pc_i + 4.
- R7: A rising edge on irq_i[0] sets a non-maskable pending flag that remains set until taken. It is taken whatever the enable bit and priority field hold, and it redirects to NMI_PC.
- R8: While in_dslot_i is high, no hardware request (maskable or non-maskable) is taken. A request still pending is taken on the next valid instruction outside a delay slot.
- R9: When several requests compete in one cycle, the order is: non-maskable first, then trap, then maskable interrupt, then trap-return or status write.
- R10: A trap-return (is_tret_i) redirects to tret_addr_i, copies the shadow copy into the status word and does not pulse ret_we_o.
- R11: redir_o, redir_pc_o and ret_addr_o appear one cycle after the accepting edge. redir_o is a single-cycle pulse, and nothing is taken in the cycle in which redir_o is high, because the instruction in that cycle is flushed.
- R12: With IRQ_EN = 0, irq_i has no effect, while traps, trap-returns and status writes behave as described above.
- R13: A valid instruction with no class flag set (an unrecognised opcode) causes no redirect and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Request lines; bit 0 non-maskable (edge), others maskable (level) |
| valid_i | input | 1 | Execute-stage instruction valid |
| in_dslot_i | input | 1 | Execute-stage instruction sits in a branch delay slot |
| is_trap_i | input | 1 | Instruction is a software trap |
| trap_num_i | input | 6 | Trap number |
| is_tret_i | input | 1 | Instruction is a trap-return |
| tret_addr_i | input | XLEN | Return target operand of the trap-return |
| pc_i | input | XLEN | Address of the execute-stage instruction |
| st_we_i | input | 1 | Status write from a control-register instruction |
| st_wdata_i | input | 8 | Status write data |
| vec_we_i | input | 1 | Vector table write strobe |
| vec_idx_i | input | 6 | Vector table write index |
| vec_data_i | input | XLEN | Vector table write data |
| redir_o | output | 1 | One-cycle redirect pulse; pipeline flushes younger work |
| redir_pc_o | output | XLEN | Redirect target |
| ret_we_o | output | 1 | Return address write pulse |
| ret_addr_o | output | XLEN | Return address to save |
| status_o | output | 8 | Current status word |
| saved_status_o | output | 8 | Shadow copy of the status word |

## Verification
Every decision is made from the inputs present before a rising edge. The redirect, target, return address and both status words therefore all change at that one edge, and a stimulus takes effect one cycle later. The bench drives inputs on the falling edge and advances a behavioural model on the rising edge. It compares every output on the next falling edge, so each result is sampled in the cycle it is due. Directed checks that follow each stimulus, for example a flushed trap in the redirect cycle or a pending non-maskable request released after a delay slot, sample at that same falling edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PRI_W   = 6;
  localparam int NIRQ    = 1 << PRI_W;
  localparam int ST_W    = 8;
  localparam int IE_BIT  = 7;
  localparam int USR_BIT = 6;

  typedef logic [PRI_W-1:0] num_t;
  typedef logic [ST_W-1:0]  stat_t;

  localparam stat_t ST_RST = stat_t'(NIRQ - 1);
endpackage

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
  parameter  int N  = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:1]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins: scan downward, last hit sticks
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/trap_vec_tbl.sv
module trap_vec_tbl #(
  parameter  int DEPTH = 64,
  parameter  int XLEN  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   widx_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   ridx_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [DEPTH-1:0][XLEN-1:0] ent;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && widx_i == AW'(g))    q <= wdata_i;
    end
    assign ent[g] = q;
  end

  assign rdata_o = ent[ridx_i];
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  take_i,
  input  num_t  num_i,
  input  logic  tret_i,
  input  logic  we_i,
  input  stat_t wdata_i,
  output stat_t status_o,
  output stat_t saved_o
);
  stat_t st_q, sv_q, st_take;

  always_comb begin
    st_take                 = st_q;
    st_take[IE_BIT]         = 1'b0;
    st_take[PRI_W-1:0]      = num_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RST;
      sv_q <= '0;
    end else if (take_i) begin
      sv_q <= st_q;
      st_q <= st_take;
    end else if (tret_i) begin
      st_q <= sv_q;
    end else if (we_i) begin
      st_q <= wdata_i;
    end
  end

  assign status_o = st_q;
  assign saved_o  = sv_q;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int          XLEN   = 32,
  parameter logic [31:0] NMI_PC = 32'h0000_0040,
  parameter bit          IRQ_EN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [63:0]     irq_i,
  input  logic            valid_i,
  input  logic            in_dslot_i,
  input  logic            is_trap_i,
  input  logic [5:0]      trap_num_i,
  input  logic            is_tret_i,
  input  logic [XLEN-1:0] tret_addr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            st_we_i,
  input  logic [7:0]      st_wdata_i,
  input  logic            vec_we_i,
  input  logic [5:0]      vec_idx_i,
  input  logic [XLEN-1:0] vec_data_i,
  output logic            redir_o,
  output logic [XLEN-1:0] redir_pc_o,
  output logic            ret_we_o,
  output logic [XLEN-1:0] ret_addr_o,
  output logic [7:0]      status_o,
  output logic [7:0]      saved_status_o
);
  stat_t           st, sv;
  logic            ie;
  num_t            pri;
  logic            go, hw_ok;
  logic            nmi_req, mi_any;
  num_t            mi_num;
  logic            nmi_take, trap_take, mi_take, tret_take, wr_take, take;
  num_t            tk_num;
  logic [XLEN-1:0] vec_rd, tgt, ret;
  logic            redir_q, ret_we_q;
  logic [XLEN-1:0] pc_q, ret_q;

  assign ie  = st[IE_BIT];
  assign pri = st[PRI_W-1:0];

  // flushed slot during redirect; delay slot blocks hardware requests only
  assign go    = valid_i & ~redir_q;
  assign hw_ok = go & ~in_dslot_i;

  if (IRQ_EN) begin : g_irq
    logic irq0_q, pend_q;
    assign nmi_req = pend_q | (irq_i[0] & ~irq0_q);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq0_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        irq0_q <= irq_i[0];
        pend_q <= nmi_req & ~nmi_take;
      end
    end
    trap_prio_enc #(.N(NIRQ)) u_pe (
      .req_i (irq_i[NIRQ-1:1]),
      .any_o (mi_any),
      .idx_o (mi_num)
    );
  end else begin : g_noirq
    assign nmi_req = 1'b0;
    assign mi_any  = 1'b0;
    assign mi_num  = '0;
  end

  assign nmi_take  = hw_ok & nmi_req;
  assign trap_take = go & is_trap_i & ~nmi_take;
  assign mi_take   = hw_ok & mi_any & ie & (mi_num < pri) & ~nmi_take & ~trap_take;
  assign take      = nmi_take | trap_take | mi_take;
  assign tret_take = go & is_tret_i & ~take;
  assign wr_take   = go & st_we_i & ~take & ~tret_take;

  always_comb begin
    if (nmi_take)       tk_num = '0;
    else if (trap_take) tk_num = trap_num_i;
    else                tk_num = mi_num;
  end

  trap_vec_tbl #(.DEPTH(NIRQ), .XLEN(XLEN)) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vec_we_i),
    .widx_i  (vec_idx_i),
    .wdata_i (vec_data_i),
    .ridx_i  (tk_num),
    .rdata_o (vec_rd)
  );

  always_comb begin
    if (nmi_take)       tgt = XLEN'(NMI_PC);
    else if (tret_take) tgt = tret_addr_i;
    else                tgt = vec_rd;
  end

  assign ret = trap_take ? pc_i + XLEN'(4) : pc_i;

  trap_status_reg u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .num_i    (tk_num),
    .tret_i   (tret_take),
    .we_i     (wr_take),
    .wdata_i  (st_wdata_i),
    .status_o (st),
    .saved_o  (sv)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redir_q  <= 1'b0;
      ret_we_q <= 1'b0;
      pc_q     <= '0;
      ret_q    <= '0;
    end else begin
      redir_q  <= take | tret_take;
      ret_we_q <= take;
      if (take | tret_take) pc_q  <= tgt;
      if (take)             ret_q <= ret;
    end
  end

  assign redir_o        = redir_q;
  assign redir_pc_o     = pc_q;
  assign ret_we_o       = ret_we_q;
  assign ret_addr_o     = ret_q;
  assign status_o       = st;
  assign saved_status_o = sv;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       in_dslot_i,
  input logic       is_trap_i,
  input logic       is_tret_i,
  input logic       redir_o,
  input logic       ret_we_o,
  input logic [7:0] status_o,
  input logic [7:0] saved_status_o
);
  AST_REDIR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_o |=> !redir_o); // R11
  AST_RET_WITH_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_we_o |-> redir_o); // R5
  AST_IE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_we_o |-> !status_o[7]); // R4
  AST_SHADOW_SAVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_we_o |-> saved_status_o == $past(status_o)); // R4
  AST_DSLOT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_dslot_i && !is_trap_i && !is_tret_i) |=> !redir_o); // R8
  AST_TRET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redir_o && !ret_we_o) |-> status_o == $past(saved_status_o)); // R10
endmodule

bind trap_ctrl trap_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .in_dslot_i     (in_dslot_i),
  .is_trap_i      (is_trap_i),
  .is_tret_i      (is_tret_i),
  .redir_o        (redir_o),
  .ret_we_o       (ret_we_o),
  .status_o       (status_o),
  .saved_status_o (saved_status_o)
);

// File: tb/sim_trap_ctrl.sv
`timescale 1ns/1ps
module sim_trap_ctrl;
  localparam logic [31:0] NMI = 32'h0000_0040;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] irq;
  logic        valid, dslot, trap, tret, swe, vwe;
  logic [5:0]  tnum, vidx;
  logic [31:0] taddr, pc, vdat;
  logic [7:0]  swd;

  logic [1:0]       o_redir, o_rwe;
  logic [1:0][31:0] o_pc, o_ret;
  logic [1:0][7:0]  o_st, o_sv;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  trap_ctrl #(.NMI_PC(NMI), .IRQ_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .valid_i(valid), .in_dslot_i(dslot),
    .is_trap_i(trap), .trap_num_i(tnum), .is_tret_i(tret), .tret_addr_i(taddr),
    .pc_i(pc), .st_we_i(swe), .st_wdata_i(swd), .vec_we_i(vwe), .vec_idx_i(vidx),
    .vec_data_i(vdat), .redir_o(o_redir[0]), .redir_pc_o(o_pc[0]), .ret_we_o(o_rwe[0]),
    .ret_addr_o(o_ret[0]), .status_o(o_st[0]), .saved_status_o(o_sv[0]));

  trap_ctrl #(.NMI_PC(NMI), .IRQ_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .valid_i(valid), .in_dslot_i(dslot),
    .is_trap_i(trap), .trap_num_i(tnum), .is_tret_i(tret), .tret_addr_i(taddr),
    .pc_i(pc), .st_we_i(swe), .st_wdata_i(swd), .vec_we_i(vwe), .vec_idx_i(vidx),
    .vec_data_i(vdat), .redir_o(o_redir[1]), .redir_pc_o(o_pc[1]), .ret_we_o(o_rwe[1]),
    .ret_addr_o(o_ret[1]), .status_o(o_st[1]), .saved_status_o(o_sv[1]));

  // behavioural reference: index 0 full build, index 1 without hardware interrupts (R12)
  logic [7:0]  m_st [2], m_sv [2];
  logic        m_rd [2], m_rwe [2], m_np [2];
  logic [31:0] m_pc [2], m_ret [2];
  logic [31:0] mvec [64];
  logic        m_irqd;

  always @(posedge clk) begin
    bit en, go, hw, nreq, ie;
    int low, pri, kind;
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_st[k] = 8'h3F; m_sv[k] = 8'h00; m_rd[k] = 0; m_rwe[k] = 0;
        m_np[k] = 0; m_pc[k] = 0; m_ret[k] = 0;
      end
      for (int i = 0; i < 64; i++) mvec[i] = 0;
      m_irqd = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        en   = (k == 0);
        go   = valid && !m_rd[k];
        hw   = go && !dslot;
        nreq = en && (m_np[k] || (irq[0] && !m_irqd));
        low  = 0;
        if (en) for (int i = 63; i >= 1; i--) if (irq[i]) low = i;
        ie   = m_st[k][7];
        pri  = int'(m_st[k][5:0]);
        kind = 0;
        if (hw && nreq)                              kind = 1;
        else if (go && trap)                         kind = 2;
        else if (hw && low != 0 && ie && low < pri)  kind = 3;
        else if (go && tret)                         kind = 4;
        else if (go && swe)                          kind = 5;
        m_np[k]  = nreq && kind != 1;
        m_rd[k]  = kind >= 1 && kind <= 4;
        m_rwe[k] = kind >= 1 && kind <= 3;
        case (kind)
          1: begin m_pc[k] = NMI; m_ret[k] = pc; m_sv[k] = m_st[k];
                   m_st[k] = {1'b0, m_st[k][6], 6'd0}; end
          2: begin m_pc[k] = mvec[tnum]; m_ret[k] = pc + 4; m_sv[k] = m_st[k];
                   m_st[k] = {1'b0, m_st[k][6], tnum}; end
          3: begin m_pc[k] = mvec[low]; m_ret[k] = pc; m_sv[k] = m_st[k];
                   m_st[k] = {1'b0, m_st[k][6], 6'(low)}; end
          4: begin m_pc[k] = taddr; m_st[k] = m_sv[k]; end
          5: m_st[k] = swd;
          default: ;
        endcase
      end
      m_irqd = irq[0];
      if (vwe) mvec[vidx] = vdat;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 2; k++) begin
        chk($sformatf("%s u%0d redir", cur_tag, k), 32'(o_redir[k]), 32'(m_rd[k]));
        chk($sformatf("%s u%0d ret_we", cur_tag, k), 32'(o_rwe[k]), 32'(m_rwe[k]));
        chk($sformatf("%s u%0d status", cur_tag, k), 32'(o_st[k]), 32'(m_st[k]));
        chk($sformatf("%s u%0d saved", cur_tag, k), 32'(o_sv[k]), 32'(m_sv[k]));
        if (m_rd[k])  chk($sformatf("%s u%0d target", cur_tag, k), o_pc[k], m_pc[k]);
        if (m_rwe[k]) chk($sformatf("%s u%0d ret", cur_tag, k), o_ret[k], m_ret[k]);
      end
    end
  end

  task automatic idle();
    irq = '0; valid = 0; dslot = 0; trap = 0; tret = 0; swe = 0; vwe = 0;
    tnum = '0; vidx = '0; taddr = '0; pc = '0; vdat = '0; swd = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) cyc();
    rst_n = 1;
    chk("R1 redir", 32'(o_redir[0]), 0);
    chk("R1 status", 32'(o_st[0]), 32'h3F);
    chk("R1 saved", 32'(o_sv[0]), 0);

    for (int i = 0; i < 64; i++) begin
      vwe = 1; vidx = 6'(i); vdat = 32'h1000 + 32'(i) * 16;
      cyc();
    end
    idle();

    cur_tag = "R13";
    valid = 1; pc = 32'h100; irq[4] = 1;
    cyc();
    chk("R13 redir", 32'(o_redir[0]), 0);
    chk("R13 status", 32'(o_st[0]), 32'h3F);
    idle();

    cur_tag = "R2";
    valid = 1; swe = 1; swd = 8'hFF;
    cyc();
    chk("R2 status", 32'(o_st[0]), 32'hFF);
    idle();

    cur_tag = "R3";
    valid = 1; pc = 32'h200; irq[5] = 1; irq[9] = 1;
    cyc();
    chk("R3 redir", 32'(o_redir[0]), 1);
    chk("R5 target", o_pc[0], 32'h1050);
    chk("R5 ret", o_ret[0], 32'h200);
    chk("R4 status", 32'(o_st[0]), 32'h45);
    chk("R4 saved", 32'(o_sv[0]), 32'hFF);
    idle();

    cur_tag = "R11";
    valid = 1; trap = 1; tnum = 6'd1; pc = 32'h204;
    cyc();
    chk("R11 redir", 32'(o_redir[0]), 0);
    chk("R11 status", 32'(o_st[0]), 32'h45);
    idle();
    cyc();

    cur_tag = "R10";
    valid = 1; tret = 1; taddr = 32'h204;
    cyc();
    chk("R10 target", o_pc[0], 32'h204);
    chk("R10 status", 32'(o_st[0]), 32'hFF);
    chk("R10 ret_we", 32'(o_rwe[0]), 0);
    idle();
    cyc();

    cur_tag = "R3";
    valid = 1; swe = 1; swd = 8'h84;
    cyc();
    idle();
    valid = 1; pc = 32'h210; irq[5] = 1;
    cyc();
    chk("R3 masked by priority", 32'(o_redir[0]), 0);
    irq[3] = 1;
    cyc();
    chk("R3 target", o_pc[0], 32'h1030);
    chk("R3 status", 32'(o_st[0]), 32'h03);
    chk("R3 saved", 32'(o_sv[0]), 32'h84);
    idle();
    cyc();

    cur_tag = "R6";
    valid = 1; trap = 1; tnum = 6'd12; pc = 32'h300;
    cyc();
    chk("R6 target", o_pc[0], 32'h10C0);
    chk("R6 ret", o_ret[0], 32'h304);
    chk("R6 status", 32'(o_st[0]), 32'h0C);
    chk("R12 trap kept", 32'(o_redir[1]), 1);
    idle();
    cyc();

    cur_tag = "R8";
    valid = 1; swe = 1; swd = 8'hBF;
    cyc();
    idle();
    valid = 1; dslot = 1; pc = 32'h3F0; irq[7] = 1;
    cyc();
    chk("R8 blocked", 32'(o_redir[0]), 0);
    dslot = 0; pc = 32'h400;
    cyc();
    chk("R8 target", o_pc[0], 32'h1070);
    chk("R8 ret", o_ret[0], 32'h400);
    chk("R12 irq ignored", 32'(o_redir[1]), 0);
    idle();
    cyc();

    cur_tag = "R7";
    valid = 1; dslot = 1; pc = 32'h4F0; irq[0] = 1;
    cyc();
    chk("R7 blocked in slot", 32'(o_redir[0]), 0);
    idle();
    cyc();
    chk("R7 no instruction", 32'(o_redir[0]), 0);
    valid = 1; pc = 32'h500;
    cyc();
    chk("R7 target", o_pc[0], NMI);
    chk("R7 ret", o_ret[0], 32'h500);
    chk("R7 status", 32'(o_st[0]), 32'h00);
    chk("R7 saved", 32'(o_sv[0]), 32'h07);
    idle();
    cyc();

    cur_tag = "R9";
    valid = 1; swe = 1; swd = 8'hBF;
    cyc();
    idle();
    valid = 1; pc = 32'h600; irq[0] = 1; irq[2] = 1; trap = 1; tnum = 6'd20;
    cyc();
    chk("R9 nmi first", o_pc[0], NMI);
    chk("R9 nmi ret", o_ret[0], 32'h600);
    idle();
    cyc();
    valid = 1; tret = 1; taddr = 32'h600;
    cyc();
    chk("R9 restored", 32'(o_st[0]), 32'hBF);
    idle();
    cyc();
    valid = 1; pc = 32'h600; irq[2] = 1; trap = 1; tnum = 6'd20;
    cyc();
    chk("R9 trap second", o_pc[0], 32'h1140);
    chk("R9 trap ret", o_ret[0], 32'h604);
    chk("R9 trap status", 32'(o_st[0]), 32'h14);
    idle();
    cyc();
    valid = 1; tret = 1; taddr = 32'h604;
    cyc();
    idle();
    cyc();
    valid = 1; pc = 32'h700; irq[2] = 1;
    cyc();
    chk("R9 maskable third", o_pc[0], 32'h1020);
    chk("R9 maskable ret", o_ret[0], 32'h700);
    chk("R9 maskable status", 32'(o_st[0]), 32'h02);
    chk("R12 no redirect", 32'(o_redir[1]), 0);
    chk("R12 status", 32'(o_st[1]), 32'hBF);
    idle();
    repeat (3) cyc();
    finish_run();
  end
endmodule